// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block sits between two 8-bit bidirectional buses, A and B. It holds one storage register for each direction. Each register has its own clock and captures the value present on its bus whenever that clock rises. For each direction, a select input picks what goes onto the far bus: the live value of the near bus, or the value held in that direction's register. A pair of enables decides which bus the block drives. The block can therefore pass data straight through, store data without driving anything, or replay stored data onto either bus while new captures continue.

Each bus side is split into an input value, an output value and an output-enable. A wrapper at the chip or bench level resolves these three signals onto the physical net. If both directions are enabled and both selects ask for live data, the two paths would form a loop. In that case the block falls back to stored data on both sides and raises a flag.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: On each rising edge of `clk_a_i`, the A register loads the resolved value of bus A (`a_i`). This happens whatever the enables and selects are.
- R2: On each rising edge of `clk_b_i`, the B register loads `b_i`. This happens whatever the enables and selects are.
- R3: When bus B is driven, `sel_ab_i` chooses its source. A value of 0 selects live `a_i`; a value of 1 selects the A register.
- R4: When bus A is driven, `sel_ba_i` chooses its source. A value of 0 selects live `b_i`; a value of 1 selects the B register.
- R5: `en_ab_i` is active high and sets `b_oe_o`. `en_ba_ni` is active low and sets `a_oe_o`.
- R6: A side whose output-enable is low presents an output value of zero. Its bus is left free for other drivers.
- R7: If both sides are enabled and both selects are 0, `loop_o` goes high and each bus is driven from the opposite register. In every other case `loop_o` is low.
- R8: A register captures the block's own driven value when its bus is being driven. A value held by an external driver that the block overrides is not captured.
- R9: `rst_ni` low clears both registers to zero at once, without waiting for a clock.
- R10: A change on a select input changes the driven output directly from the old source to the new one. No clock edge is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset of both registers |
| clk_a_i | input | 1 | Capture clock for the A register |
| clk_b_i | input | 1 | Capture clock for the B register |
| en_ab_i | input | 1 | Drive enable for bus B, active high |
| en_ba_ni | input | 1 | Drive enable for bus A, active low |
| sel_ab_i | input | 1 | Source for bus B: 0 live A, 1 stored A |
| sel_ba_i | input | 1 | Source for bus A: 0 live B, 1 stored B |
| a_i | input | 8 | Resolved value of bus A |
| a_o | output | 8 | Value the block drives onto bus A |
| a_oe_o | output | 1 | Output-enable for bus A |
| b_i | input | 8 | Resolved value of bus B |
| b_o | output | 8 | Value the block drives onto bus B |
| b_oe_o | output | 1 | Output-enable for bus B |
| loop_o | output | 1 | Both live paths requested together; stored data substituted |

## Verification
The bench goes after the case where both enables are on and both selects ask for live data. A design without the loop rule would route bus A to bus B and back, and the outputs would either oscillate or hold a stale value instead of the stored bytes. It also captures on a bus while the block drives that bus. A design that sampled the external driver instead of the resolved net would store the overridden value. Selects are flipped between clock edges to catch a design that delays the source change by a cycle. Reset is pulsed in the middle of a run to catch a register that only clears on a clock.

// File: rtl/bidir_reg_xcvr_pkg.sv
package bidir_reg_xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_AB  = 0;
  localparam int unsigned DIR_BA  = 1;
endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_src_mux.sv
module xcvr_src_mux
  import bidir_reg_xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  src_e         src_i,
  input  logic         oe_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] y_o
);
  logic pick_live, pick_stored;

  // one-hot AND-OR form: a single select term switches both legs
  assign pick_live   = oe_i & (src_i == SRC_LIVE);
  assign pick_stored = oe_i & (src_i == SRC_STORED);
  assign y_o = ({W{pick_live}} & live_i) | ({W{pick_stored}} & stored_i);
endmodule

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
  import bidir_reg_xcvr_pkg::*;
(
  input  logic en_ab_i,
  input  logic en_ba_ni,
  input  logic sel_ab_i,
  input  logic sel_ba_i,
  output logic oe_a_o,
  output logic oe_b_o,
  output src_e src_ab_o,
  output src_e src_ba_o,
  output logic loop_o
);
  logic both_on;

  assign oe_b_o  = en_ab_i;
  assign oe_a_o  = ~en_ba_ni;
  assign both_on = oe_a_o & oe_b_o;
  // live in both directions would close A->B->A; substitute stored data
  assign loop_o  = both_on & ~sel_ab_i & ~sel_ba_i;

  assign src_ab_o = (sel_ab_i | loop_o) ? SRC_STORED : SRC_LIVE;
  assign src_ba_o = (sel_ba_i | loop_o) ? SRC_STORED : SRC_LIVE;
endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr
  import bidir_reg_xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         rst_ni,
  input  logic         clk_a_i,
  input  logic         clk_b_i,
  input  logic         en_ab_i,
  input  logic         en_ba_ni,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o,
  output logic         loop_o
);
  logic         cap_clk [NUM_DIR];
  logic [W-1:0] cap_d   [NUM_DIR];
  logic [W-1:0] cap_q   [NUM_DIR];
  logic [W-1:0] far_y   [NUM_DIR];
  logic         far_oe  [NUM_DIR];
  src_e         far_src [NUM_DIR];
  src_e         src_ab, src_ba;

  xcvr_dir_ctrl u_ctrl (
    .en_ab_i  (en_ab_i),
    .en_ba_ni (en_ba_ni),
    .sel_ab_i (sel_ab_i),
    .sel_ba_i (sel_ba_i),
    .oe_a_o   (a_oe_o),
    .oe_b_o   (b_oe_o),
    .src_ab_o (src_ab),
    .src_ba_o (src_ba),
    .loop_o   (loop_o)
  );

  // direction 0: captures A, drives B; direction 1: captures B, drives A
  assign cap_clk[DIR_AB] = clk_a_i;
  assign cap_clk[DIR_BA] = clk_b_i;
  assign cap_d[DIR_AB]   = a_i;
  assign cap_d[DIR_BA]   = b_i;
  assign far_oe[DIR_AB]  = b_oe_o;
  assign far_oe[DIR_BA]  = a_oe_o;
  assign far_src[DIR_AB] = src_ab;
  assign far_src[DIR_BA] = src_ba;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    xcvr_capture_reg #(.W(W)) u_reg (
      .clk_i  (cap_clk[d]),
      .rst_ni (rst_ni),
      .d_i    (cap_d[d]),
      .q_o    (cap_q[d])
    );

    xcvr_src_mux #(.W(W)) u_mux (
      .src_i    (far_src[d]),
      .oe_i     (far_oe[d]),
      .live_i   (cap_d[d]),
      .stored_i (cap_q[d]),
      .y_o      (far_y[d])
    );
  end

  assign b_o = far_y[DIR_AB];
  assign a_o = far_y[DIR_BA];
endmodule

// File: rtl/bidir_reg_xcvr_chk.sv
module bidir_reg_xcvr_chk #(
  parameter int unsigned W = 8
) (
  input logic         rst_ni,
  input logic         clk_a_i,
  input logic         clk_b_i,
  input logic         en_ab_i,
  input logic         en_ba_ni,
  input logic         sel_ab_i,
  input logic         sel_ba_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] a_o,
  input logic         a_oe_o,
  input logic [W-1:0] b_i,
  input logic [W-1:0] b_o,
  input logic         b_oe_o,
  input logic         loop_o
);
  logic seen_a, seen_b;

  always_ff @(posedge clk_a_i or negedge rst_ni) begin
    if (!rst_ni) seen_a <= 1'b0;
    else         seen_a <= 1'b1;
  end

  always_ff @(posedge clk_b_i or negedge rst_ni) begin
    if (!rst_ni) seen_b <= 1'b0;
    else         seen_b <= 1'b1;
  end

  a_r5_enable_polarity: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (b_oe_o == en_ab_i) && (a_oe_o == !en_ba_ni));

  a_r3_live_ab: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (b_oe_o && !sel_ab_i && !loop_o) |-> (b_o == a_i));

  a_r4_live_ba: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_oe_o && !sel_ba_i && !loop_o) |-> (a_o == b_i));

  a_r6_quiet_a: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !a_oe_o |-> (a_o == '0));

  a_r6_quiet_b: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !b_oe_o |-> (b_o == '0));

  a_r7_no_live_loop: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !(a_oe_o && b_oe_o && !sel_ab_i && !sel_ba_i && !loop_o));

  a_r7_flag_needs_both: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    loop_o |-> (a_oe_o && b_oe_o));

  a_r1_stored_a_on_b: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (seen_a && b_oe_o && (sel_ab_i || loop_o)) |-> (b_o == $past(a_i)));

  a_r2_stored_b_on_a: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (seen_b && a_oe_o && (sel_ba_i || loop_o)) |-> (a_o == $past(b_i)));
endmodule

bind bidir_reg_xcvr bidir_reg_xcvr_chk #(.W(W)) u_chk (
  .rst_ni   (rst_ni),
  .clk_a_i  (clk_a_i),
  .clk_b_i  (clk_b_i),
  .en_ab_i  (en_ab_i),
  .en_ba_ni (en_ba_ni),
  .sel_ab_i (sel_ab_i),
  .sel_ba_i (sel_ba_i),
  .a_i      (a_i),
  .a_o      (a_o),
  .a_oe_o   (a_oe_o),
  .b_i      (b_i),
  .b_o      (b_o),
  .b_oe_o   (b_oe_o),
  .loop_o   (loop_o)
);

// File: tb/bidir_reg_xcvr_tb_top.sv
`timescale 1ns/1ps
module bidir_reg_xcvr_tb_top;
  localparam int unsigned W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic ca, cb;
  logic en_ab, en_ba_n, sel_ab, sel_ba;
  logic [W-1:0] ext_a, ext_b;
  logic [W-1:0] a_net, b_net, a_o, b_o;
  logic a_oe, b_oe, loop_f;
  logic clk_a, clk_b;

  int n_chk = 0;
  int n_fail = 0;

  logic [W-1:0] ma, mb;
  logic [W-1:0] ea, eb, an, bn;
  logic eoe_a, eoe_b, eloop;

  always #10 clk = ~clk;

  assign clk_a = clk & ca;
  assign clk_b = clk & cb;
  // bus resolution: block wins when enabled, otherwise the external driver
  assign a_net = a_oe ? a_o : ext_a;
  assign b_net = b_oe ? b_o : ext_b;

  bidir_reg_xcvr #(.W(W)) dut_i (
    .rst_ni   (rst_n),
    .clk_a_i  (clk_a),
    .clk_b_i  (clk_b),
    .en_ab_i  (en_ab),
    .en_ba_ni (en_ba_n),
    .sel_ab_i (sel_ab),
    .sel_ba_i (sel_ba),
    .a_i      (a_net),
    .a_o      (a_o),
    .a_oe_o   (a_oe),
    .b_i      (b_net),
    .b_o      (b_o),
    .b_oe_o   (b_oe),
    .loop_o   (loop_f)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model();
    eloop = en_ab && !en_ba_n && !sel_ab && !sel_ba;
    eoe_b = en_ab;
    eoe_a = !en_ba_n;
    an = ext_a;
    bn = ext_b;
    if (eloop) begin
      eb = ma; ea = mb; an = ea; bn = eb;
    end else begin
      for (int p = 0; p < 2; p++) begin
        ea = eoe_a ? (sel_ba ? mb : bn) : '0;
        eb = eoe_b ? (sel_ab ? ma : an) : '0;
        an = eoe_a ? ea : ext_a;
        bn = eoe_b ? eb : ext_b;
      end
    end
  endtask

  task automatic check_outs(input string tag);
    model();
    check({tag, " R5 a_oe"}, 32'(a_oe), 32'(eoe_a));
    check({tag, " R5 b_oe"}, 32'(b_oe), 32'(eoe_b));
    check({tag, " R7 loop"}, 32'(loop_f), 32'(eloop));
    check({tag, " R3/R6 b_o"}, 32'(b_o), 32'(eb));
    check({tag, " R4/R6 a_o"}, 32'(a_o), 32'(ea));
  endtask

  // inputs set while clk is low; outputs checked; one edge; model updated
  task automatic step(input string tag);
    #2;
    check_outs(tag);
    @(posedge clk);
    if (ca) ma = an;
    if (cb) mb = bn;
    @(negedge clk);
  endtask

  task automatic set(input logic ea_, input logic eb_n, input logic sa, input logic sb,
                     input logic [W-1:0] xa, input logic [W-1:0] xb,
                     input logic c_a, input logic c_b);
    en_ab = ea_; en_ba_n = eb_n; sel_ab = sa; sel_ba = sb;
    ext_a = xa; ext_b = xb; ca = c_a; cb = c_b;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    rst_n = 1'b0;
    ma = '0; mb = '0;
    set(1'b1, 1'b0, 1'b1, 1'b1, 8'h5a, 8'ha5, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    // R9: reset state, stored data on both sides reads zero
    #2;
    check("R9 reset a_o", 32'(a_o), 32'h0);
    check("R9 reset b_o", 32'(b_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2: capture with no outputs driven
    set(1'b0, 1'b1, 1'b0, 1'b0, 8'h3c, 8'hc3, 1'b1, 1'b1);
    step("R1 R2 capture idle");
    // R6: idle sides read zero
    check("R6 idle a_o", 32'(a_o), 32'h0);
    check("R6 idle b_o", 32'(b_o), 32'h0);
    // stored replay both ways
    set(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0);
    step("R1 R2 stored replay");
    check("R1 stored a on b", 32'(b_o), 32'h3c);
    check("R2 stored b on a", 32'(a_o), 32'hc3);

    // R7: loop case drives stored data and raises the flag
    set(1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 1'b0, 1'b0);
    step("R7 loop");
    check("R7 loop b_o", 32'(b_o), 32'h3c);
    check("R7 loop a_o", 32'(a_o), 32'hc3);

    // R8: A driven with stored B while external A differs; A reg captures driven value
    set(1'b0, 1'b0, 1'b1, 1'b1, 8'hee, 8'h99, 1'b1, 1'b0);
    step("R8 capture driven");
    set(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0);
    step("R8 readback");
    check("R8 A reg holds driven byte", 32'(b_o), 32'hc3);

    // R10: select flipped between edges takes effect without a clock
    set(1'b1, 1'b1, 1'b0, 1'b0, 8'h77, 8'h00, 1'b0, 1'b0);
    #2;
    check("R10 live before flip", 32'(b_o), 32'h77);
    sel_ab = 1'b1;
    #1;
    check("R10 stored after flip", 32'(b_o), 32'hc3);
    sel_ab = 1'b0;
    #1;
    check("R10 live after flip back", 32'(b_o), 32'h77);
    @(negedge clk);

    // R9: reset mid-run without a clock edge
    set(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0);
    #2;
    rst_n = 1'b0;
    #1;
    check("R9 async clear b_o", 32'(b_o), 32'h0);
    check("R9 async clear a_o", 32'(a_o), 32'h0);
    ma = '0; mb = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // random mix covering R1..R8
    for (int i = 0; i < 2000; i++) begin
      set(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
      step("rand");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule